// File: doc/BRIEF.md
# Interrupt Redirection Dispatch Engine

This block turns a bank of interrupt request lines into a stream of delivery messages, one at a time. Each pin has a 64-bit routing entry held by a neighbouring register block and presented here as a flat bus. The entry gives the pin's mask, trigger style and the message fields. The block keeps a pending bit per pin. It picks the lowest-numbered pending pin whose entry is not masked and presents that pin's message on a valid/ready port.

Edge-style pins are retired when their message is accepted. Level-style pins follow their input and fire again for as long as the line stays high. One delivery code (3'b111) takes its vector from an external legacy controller rather than from the entry. The block asks for that vector with a one-cycle strobe and waits for the answer before it offers the message. Request line 0 is steered onto pin 2, so pin 0 never raises a request.

Top module: `irq_dispatch`

## Requirements
- R1: While reset is held and after it is released, `msg_valid` and `ext_req` are 0 and no pin is pending.
- R2: Entry bit 16 set masks a pin: a pending request on that pin produces no message and stays pending, so it is offered once bit 16 is cleared.
- R3: An offered message carries the selected entry's bits 63:56 as destination, bit 11 as destination mode, bits 10:8 as delivery code, bits 7:0 as vector, bit 13 as polarity and bit 15 as trigger style.
- R4: With entry bit 15 = 0 (edge), a 0-to-1 change of the pin input sets the pending bit. An accepted message for that pin clears it, and a line that stays high or goes low does not set it again or clear it.
- R5: With entry bit 15 = 1 (level), the pending bit equals the pin input of the previous cycle and is not cleared by acceptance, so a held-high line is offered repeatedly.
- R6: Of all unmasked pending pins, the lowest index is offered first, and the choice is made afresh from pin 0 after every acceptance.
- R7: For delivery code 3'b111, `ext_req` pulses for exactly one cycle, no message is offered until `ext_vec_valid` is seen, and the message vector is the `ext_vec` value sampled with it.
- R8: Request line 0 drives pin 2 (ORed with line 2), pin 0 receives no request, and every other line drives the pin of the same index.
- R9: Once `msg_valid` is high, it and all message fields hold unchanged until a cycle in which `msg_ready` is high.
- R10: If an edge pin sees a new rising input in the same cycle that its message is accepted, the pin stays pending and is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | N_PINS | Request lines, synchronous to clk |
| route_table | input | N_PINS*64 | Routing entries, entry i at bits i*64+63 : i*64 |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dlv_mode | output | 3 | Delivery code |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity |
| msg_trig | output | 1 | Trigger style, 1 = level |
| ext_req | output | 1 | One-cycle request for an external vector |
| ext_vec_valid | input | 1 | External vector returned |
| ext_vec | input | 8 | External vector value |

## Verification
Retiring an accepted edge request and capturing a fresh rising edge on the same pin can land on the same clock edge. The bench provokes this by raising the line in exactly the cycle in which it asserts ready for that pin's pending offer. The behavioural model predicts that the bit stays set, and its per-cycle comparison expects a second offer of the same vector. A model that lets the clear win would predict silence there, so the verdict hinges on that one cycle.

// File: rtl/irqd_pkg.sv
// Package: shared types for the dispatch engine.
// Assumes 64-bit routing entries with fixed field positions.
package irqd_pkg;
    localparam int ENTRY_W = 64;
    localparam logic [2:0] DLV_EXTERNAL = 3'b111;

    typedef enum logic [1:0] {
        ST_SCAN     = 2'd0,
        ST_EXT_ASK  = 2'd1,
        ST_EXT_WAIT = 2'd2,
        ST_OFFER    = 2'd3
    } disp_state_t;

    typedef struct packed {
        logic [7:0] dest;
        logic       dest_mode;
        logic [2:0] dlv;
        logic [7:0] vector;
        logic       polarity;
        logic       trig;
        logic       masked;
    } route_t;

    // Pull the fields that the engine needs out of one routing entry.
    function automatic route_t decode_route(input logic [ENTRY_W-1:0] e);
        route_t r;
        r.dest      = e[63:56];
        r.masked    = e[16];
        r.trig      = e[15];
        r.polarity  = e[13];
        r.dest_mode = e[11];
        r.dlv       = e[10:8];
        r.vector    = e[7:0];
        return r;
    endfunction
endpackage

// File: rtl/irqd_capture.sv
// Module: irqd_capture
// Maps request lines onto pins and keeps one pending bit per pin.
// Level pins copy their input; edge pins set on a rising input and
// clear on an accepted delivery, with a new rise winning over the clear.
// Assumes lines are already synchronous to clk.
module irqd_capture #(
    parameter int N_PINS   = 24,
    parameter int LINE_SRC = 0,
    parameter int LINE_DST = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PINS-1:0]         lines,
    input  logic [N_PINS-1:0]         lvl_mode,
    input  logic                      clr_en,
    input  logic [$clog2(N_PINS)-1:0] clr_idx,
    output logic [N_PINS-1:0]         pend
);
    localparam int IDX_W = $clog2(N_PINS);

    logic [N_PINS-1:0] pin_in;
    logic [N_PINS-1:0] pin_prev;
    logic [N_PINS-1:0] rise;

    // Line-to-pin steering: the source line is folded into the target pin.
    for (genvar g = 0; g < N_PINS; g++) begin : g_map
        if (g == LINE_DST) begin : g_dst
            assign pin_in[g] = lines[g] | lines[LINE_SRC];
        end else if (g == LINE_SRC) begin : g_src
            assign pin_in[g] = 1'b0;
        end else begin : g_direct
            assign pin_in[g] = lines[g];
        end
    end

    assign rise = pin_in & ~pin_prev;

    // Remember last cycle's pin inputs for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= '0;
        else        pin_prev <= pin_in;
    end

    // Update pending bits per pin according to its trigger style.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            for (int i = 0; i < N_PINS; i++) begin
                if (lvl_mode[i])
                    pend[i] <= pin_in[i];
                else
                    pend[i] <= rise[i] |
                               (pend[i] & ~(clr_en && (clr_idx == IDX_W'(i))));
            end
        end
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_chk
        AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && lvl_mode[g] && pin_in[g]) |-> pend[g]); // R5
        AST_EDGE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && clr_en && clr_idx == IDX_W'(g) && !lvl_mode[g] && !rise[g]) |-> !pend[g]); // R4
        AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && !lvl_mode[g] && pend[g] && !(clr_en && clr_idx == IDX_W'(g))) |-> pend[g]); // R4
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && !lvl_mode[g] && rise[g]) |-> pend[g]); // R10
    end
endmodule

// File: rtl/irqd_pick.sv
// Module: irqd_pick
// Fixed-priority selector: lowest-index pin that is pending and unmasked.
// Purely combinational; clk/rst_n serve only the checks.
module irqd_pick #(
    parameter int N_PINS = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PINS-1:0]         pend,
    input  logic [N_PINS-1:0]         mask,
    output logic                      found,
    output logic [$clog2(N_PINS)-1:0] idx
);
    localparam int IDX_W = $clog2(N_PINS);

    logic [N_PINS-1:0] eligible;
    assign eligible = pend & ~mask;

    // Walk from the top down so the lowest eligible index is kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_PINS - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((pend & ~mask & ((N_PINS'(1) << idx) - N_PINS'(1))) == '0)); // R6
    AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !mask[idx]); // R2
endmodule

// File: rtl/irq_dispatch.sv
// Module: irq_dispatch (top)
// Scans pending pins against the routing entries, fetches an external
// vector when the delivery code asks for it, and offers one message at a
// time on a valid/ready port. Assumes route_table is stable while read
// and that all inputs are synchronous to clk.
module irq_dispatch #(
    parameter int N_PINS   = 24,
    parameter int LINE_SRC = 0,
    parameter int LINE_DST = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_PINS-1:0]            irq_lines,
    input  logic [N_PINS*64-1:0]         route_table,
    output logic                         msg_valid,
    input  logic                         msg_ready,
    output logic [7:0]                   msg_dest,
    output logic                         msg_dest_mode,
    output logic [2:0]                   msg_dlv_mode,
    output logic [7:0]                   msg_vector,
    output logic                         msg_polarity,
    output logic                         msg_trig,
    output logic                         ext_req,
    input  logic                         ext_vec_valid,
    input  logic [7:0]                   ext_vec
);
    import irqd_pkg::*;
    localparam int IDX_W = $clog2(N_PINS);

    route_t            entries [N_PINS];
    logic [N_PINS-1:0] mask_v;
    logic [N_PINS-1:0] lvl_v;
    logic [N_PINS-1:0] pend;
    logic              found;
    logic [IDX_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  sel_idx;
    disp_state_t       state;
    logic              accept;
    route_t            pick_r;

    for (genvar g = 0; g < N_PINS; g++) begin : g_dec
        assign entries[g] = decode_route(route_table[g*ENTRY_W +: ENTRY_W]);
        assign mask_v[g]  = entries[g].masked;
        assign lvl_v[g]   = entries[g].trig;
    end

    assign pick_r    = entries[pick_idx];
    assign accept    = (state == ST_OFFER) && msg_ready;
    assign msg_valid = (state == ST_OFFER);
    assign ext_req   = (state == ST_EXT_ASK);

    irqd_capture #(.N_PINS(N_PINS), .LINE_SRC(LINE_SRC), .LINE_DST(LINE_DST)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_lines),
        .lvl_mode (lvl_v),
        .clr_en   (accept && !msg_trig),
        .clr_idx  (sel_idx),
        .pend     (pend)
    );

    irqd_pick #(.N_PINS(N_PINS)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .mask  (mask_v),
        .found (found),
        .idx   (pick_idx)
    );

    // Dispatch sequencer: select, optionally fetch vector, offer, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_SCAN;
            sel_idx       <= '0;
            msg_dest      <= '0;
            msg_dest_mode <= 1'b0;
            msg_dlv_mode  <= '0;
            msg_vector    <= '0;
            msg_polarity  <= 1'b0;
            msg_trig      <= 1'b0;
        end else begin
            case (state)
                ST_SCAN: begin
                    if (found) begin
                        sel_idx       <= pick_idx;
                        msg_dest      <= pick_r.dest;
                        msg_dest_mode <= pick_r.dest_mode;
                        msg_dlv_mode  <= pick_r.dlv;
                        msg_vector    <= pick_r.vector;
                        msg_polarity  <= pick_r.polarity;
                        msg_trig      <= pick_r.trig;
                        state <= (pick_r.dlv == DLV_EXTERNAL) ? ST_EXT_ASK : ST_OFFER;
                    end
                end
                ST_EXT_ASK: state <= ST_EXT_WAIT;
                ST_EXT_WAIT: begin
                    if (ext_vec_valid) begin
                        msg_vector <= ext_vec;
                        state      <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (msg_ready) state <= ST_SCAN;
                end
                default: state <= ST_SCAN;
            endcase
        end
    end

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid &&
        $stable({msg_dest, msg_dest_mode, msg_dlv_mode, msg_vector, msg_polarity, msg_trig})); // R9
    AST_EXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |=> !ext_req && !msg_valid); // R7
    AST_EXT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXT_WAIT && ext_vec_valid) |=> msg_valid && msg_vector == $past(ext_vec)); // R7
    AST_PIN0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !pend[LINE_SRC]); // R8
endmodule

// File: tb/sim_irq_dispatch.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios for each requirement.
module sim_irq_dispatch;
    localparam int N = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    lines = '0;
    logic [N*64-1:0] tbl;
    logic            ready = 1'b0;
    logic            evv = 1'b0;
    logic [7:0]      ev = '0;
    logic [7:0]      resp_vec = 8'h99;

    logic       msg_valid, msg_dest_mode, msg_polarity, msg_trig, ext_req;
    logic [7:0] msg_dest, msg_vector;
    logic [2:0] msg_dlv_mode;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit started = 0;

    always #2 clk = ~clk;

    irq_dispatch #(.N_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .route_table(tbl),
        .msg_valid(msg_valid), .msg_ready(ready), .msg_dest(msg_dest),
        .msg_dest_mode(msg_dest_mode), .msg_dlv_mode(msg_dlv_mode),
        .msg_vector(msg_vector), .msg_polarity(msg_polarity), .msg_trig(msg_trig),
        .ext_req(ext_req), .ext_vec_valid(evv), .ext_vec(ev)
    );

    // ---------------- reference model ----------------
    bit       m_pend [N];
    bit       m_prev [N];
    int       m_state = 0;   // 0 scan, 1 ask, 2 wait, 3 offer
    int       m_sel = 0;
    bit [7:0] m_dest, m_vec;
    bit       m_dm, m_pol, m_trig;
    bit [2:0] m_dlv;

    function automatic bit [63:0] ent(int i);
        return tbl[i*64 +: 64];
    endfunction

    function automatic bit pin(int i);
        if (i == 0) return 1'b0;
        if (i == 2) return lines[0] | lines[2];
        return lines[i];
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
            m_state = 0; m_sel = 0; m_dest = 0; m_vec = 0;
            m_dm = 0; m_pol = 0; m_trig = 0; m_dlv = 0;
        end else begin
            bit clr_any;
            int clr_pin;
            int pick;
            clr_any = (m_state == 3) && ready && !m_trig;
            clr_pin = m_sel;
            pick = -1;
            for (int i = 0; i < N; i++)
                if (pick < 0 && m_pend[i] && !ent(i)[16]) pick = i;
            case (m_state)
                0: if (pick >= 0) begin
                    bit [63:0] e;
                    e = ent(pick);
                    m_sel = pick; m_dest = e[63:56]; m_dm = e[11]; m_dlv = e[10:8];
                    m_vec = e[7:0]; m_pol = e[13]; m_trig = e[15];
                    m_state = (e[10:8] == 3'b111) ? 1 : 3;
                end
                1: m_state = 2;
                2: if (evv) begin m_vec = ev; m_state = 3; end
                default: if (ready) m_state = 0;
            endcase
            for (int i = 0; i < N; i++) begin
                bit p;
                p = pin(i);
                if (ent(i)[15]) m_pend[i] = p;
                else m_pend[i] = (p && !m_prev[i]) || (m_pend[i] && !(clr_any && clr_pin == i));
                m_prev[i] = p;
            end
        end
    end

    // External legacy controller stand-in: answers two cycles after waiting starts.
    int wcnt = 0;
    always @(negedge clk) begin
        if (m_state == 2) begin
            wcnt = wcnt + 1;
            evv = (wcnt == 2);
            ev  = (wcnt == 2) ? resp_vec : 8'h00;
        end else begin
            wcnt = 0;
            evv = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (started) begin
            chk(msg_valid == (m_state == 3), "R6 msg_valid", msg_valid, m_state == 3);
            chk(ext_req == (m_state == 1), "R7 ext_req", ext_req, m_state == 1);
            if (m_state == 3) begin
                chk({msg_dest, msg_dest_mode, msg_dlv_mode, msg_polarity, msg_trig} ==
                    {m_dest, m_dm, m_dlv, m_pol, m_trig}, "R3 fields",
                    {msg_dest, msg_dest_mode, msg_dlv_mode, msg_polarity, msg_trig},
                    {m_dest, m_dm, m_dlv, m_pol, m_trig});
                chk(msg_vector == m_vec, "R3 vector", msg_vector, m_vec);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_entry(input int i, input bit [7:0] dest, input bit dm, input bit pol,
                             input bit lvl, input bit [2:0] dlv, input bit [7:0] vec, input bit msk);
        bit [63:0] e;
        e = '0;
        e[63:56] = dest; e[16] = msk; e[15] = lvl; e[13] = pol;
        e[11] = dm; e[10:8] = dlv; e[7:0] = vec;
        tbl[i*64 +: 64] = e;
    endtask

    task automatic pulse(input int i);
        lines[i] = 1'b1; step(1); lines[i] = 1'b0;
    endtask

    task automatic wait_offer();
        for (int k = 0; k < 30; k++) begin
            if (msg_valid) break;
            step(1);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        for (int i = 0; i < N; i++) set_entry(i, 8'h00, 0, 0, 0, 3'd0, 8'h00, 1);
        step(3);
        chk(msg_valid == 0, "R1 valid in reset", msg_valid, 0);
        chk(ext_req == 0, "R1 ext_req in reset", ext_req, 0);
        rst_n = 1'b1;
        step(3);
        chk(msg_valid == 0, "R1 valid after reset", msg_valid, 0);

        // R3/R9: fields and hold while not ready; R4: held-high edge line fires once.
        set_entry(5, 8'hA5, 1, 1, 0, 3'd0, 8'h35, 0);
        lines[5] = 1'b1;
        step(6);
        chk(msg_valid == 1, "R9 offer held", msg_valid, 1);
        chk(msg_vector == 8'h35, "R3 vector", msg_vector, 8'h35);
        chk(msg_dest == 8'hA5, "R3 dest", msg_dest, 8'hA5);
        ready = 1'b1;
        step(1);
        cnt = 0;
        for (int k = 0; k < 6; k++) begin step(1); cnt += msg_valid; end
        chk(cnt == 0, "R4 edge fires once", cnt, 0);
        lines[5] = 1'b0;
        step(2);

        // R5: level pin keeps firing while high, stops after it drops.
        set_entry(7, 8'h07, 0, 0, 1, 3'd1, 8'h47, 0);
        lines[7] = 1'b1;
        cnt = 0;
        for (int k = 0; k < 12; k++) begin step(1); cnt += msg_valid; end
        chk(cnt >= 2, "R5 level repeats", cnt, 2);
        lines[7] = 1'b0;
        step(4);
        cnt = 0;
        for (int k = 0; k < 8; k++) begin step(1); cnt += msg_valid; end
        chk(cnt == 0, "R5 level stops", cnt, 0);

        // R2: masked pin stays pending, offered after unmask.
        set_entry(9, 8'h09, 0, 0, 0, 3'd0, 8'h59, 1);
        pulse(9);
        cnt = 0;
        for (int k = 0; k < 6; k++) begin step(1); cnt += msg_valid; end
        chk(cnt == 0, "R2 masked silent", cnt, 0);
        set_entry(9, 8'h09, 0, 0, 0, 3'd0, 8'h59, 0);
        step(1);
        wait_offer();
        chk(msg_vector == 8'h59, "R2 offered after unmask", msg_vector, 8'h59);
        step(3);

        // R6: two pins at once, lower index first.
        set_entry(3, 8'h03, 0, 0, 0, 3'd0, 8'h33, 0);
        set_entry(12, 8'h0C, 0, 0, 0, 3'd0, 8'h3C, 0);
        ready = 1'b0;
        lines[3] = 1'b1; lines[12] = 1'b1; step(1); lines[3] = 1'b0; lines[12] = 1'b0;
        wait_offer();
        chk(msg_vector == 8'h33, "R6 low pin first", msg_vector, 8'h33);
        ready = 1'b1; step(1); ready = 1'b0;
        wait_offer();
        chk(msg_vector == 8'h3C, "R6 next pin", msg_vector, 8'h3C);
        ready = 1'b1;
        step(3);

        // R7: external vector substitution.
        set_entry(4, 8'h44, 0, 0, 0, 3'b111, 8'h11, 0);
        pulse(4);
        cnt = 0;
        for (int k = 0; k < 6; k++) begin cnt += ext_req; step(1); end
        chk(cnt == 1, "R7 one strobe", cnt, 1);
        wait_offer();
        chk(msg_vector == 8'h99, "R7 external vector", msg_vector, 8'h99);
        chk(msg_dlv_mode == 3'b111, "R7 delivery code", msg_dlv_mode, 3'b111);
        step(3);

        // R8: line 0 lands on pin 2; pin 0 never fires.
        set_entry(2, 8'h22, 0, 0, 0, 3'd0, 8'h22, 0);
        set_entry(0, 8'h00, 0, 0, 0, 3'd0, 8'h0A, 0);
        ready = 1'b0;
        pulse(0);
        wait_offer();
        chk(msg_vector == 8'h22, "R8 line0 to pin2", msg_vector, 8'h22);
        ready = 1'b1;
        step(1);
        cnt = 0;
        for (int k = 0; k < 6; k++) begin step(1); cnt += msg_valid; end
        chk(cnt == 0, "R8 pin0 quiet", cnt, 0);

        // R10: new rise on the acceptance cycle keeps the pin pending.
        set_entry(6, 8'h66, 0, 0, 0, 3'd0, 8'h66, 0);
        ready = 1'b0;
        pulse(6);
        wait_offer();
        chk(msg_vector == 8'h66, "R10 first offer", msg_vector, 8'h66);
        lines[6] = 1'b1; ready = 1'b1;
        step(1);
        lines[6] = 1'b0; ready = 1'b0;
        wait_offer();
        chk(msg_valid == 1 && msg_vector == 8'h66, "R10 second offer", msg_vector, 8'h66);
        ready = 1'b1;
        step(6);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule